// File: doc/BRIEF.md
# SPI Master/Slave Port

A single-channel, 8-bit, full-duplex serial peripheral port. It uses four wires: serial clock, master-out data, master-in data and an active-low select. A mode bit makes the same engine act as bus master or as slave. As master it generates the serial clock from the system clock at one of four rates. Clock idle level, sampling phase and bit order are all selectable at run time. Software uses a small register bus with three locations: control, status and data. Writing the data location hands a byte to the engine. Reading it returns the last byte received.

Each completed byte raises a completion flag. When the interrupt is enabled, that flag drives `irq` and the acknowledge input clears it; otherwise software clears it by writing 0. A data write made while a byte is moving is dropped and recorded in a collision flag. In slave mode the select can rise before a byte ends. The partial byte is then discarded, the bit position returns to the start, and a flag records the event. The data location exerts no back-pressure: every write is accepted at once, and the collision flag records a write that could not be used.

Top module: `spi_port_top`

## Requirements
- R1: After reset, `irq` is 0, every `*_oe` output is 0, `ss_n_o` is 1, and all three registers read 0.
- R2: Register map. Address 0 is control: bit 7 enable, bit 6 LSB-first, bit 5 CPOL, bit 4 CPHA, bit 3 master, bit 2 interrupt enable, bits 1:0 rate. Address 1 is status: bit 0 done, bit 1 collision, bit 2 select-rose, bit 3 auto-select. Address 2 is data. As master, the serial clock half-period is 2, 4, 8 or 16 system clocks for rate 0..3, giving the system clock divided by 4, 8, 16 or 32. A byte takes 8 clock periods, and `sck_o` idles at CPOL. The first toggle comes one half-period after the clock edge that takes the data write.
- R3: With CPHA=0, data is sampled on odd clock edges (1, 3, ...) and the outgoing bit changes on even edges. With CPHA=1, the outgoing bit changes on edges 3, 5, ... and data is sampled on even edges.
- R4: With LSB-first set, bit 0 goes out first; otherwise bit 7 goes out first. Received bits are placed the same way.
- R5: As master, the byte sampled from `miso_i` is readable at the data address after the transfer.
- R6: The done flag sets one system clock after the last serial clock edge of a byte.
- R7: With interrupt enable set, `irq` follows the done flag and `irq_ack` clears it. With it clear, `irq` stays 0, `irq_ack` has no effect, and only a status write with bit 0 = 0 clears the flag.
- R8: A data write while a byte is in progress sets the collision flag and is discarded: the byte on the wire is unchanged.
- R9: As slave, the port shifts on `sck_i` edges while `ss_n_i` is low. It drives `miso_o` (with `miso_oe`) from the loaded byte and stores the byte taken from `mosi_i`. Master and slave output enables are never active together.
- R10: As slave, `ss_n_i` rising mid-byte sets the select-rose flag, abandons the byte and resets the bit position, so the next load and transfer are complete and correct.
- R11: As master with auto-select set, `ss_n_oe` is 1, and `ss_n_o` is low from the data write until the cycle after the last edge.
- R12: With enable clear, a data write starts nothing: no done flag, no select, and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out data in (slave) |
| mosi_o | output | 1 | Master-out data out (master) |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Master-in data in (master) |
| miso_o | output | 1 | Master-in data out (slave) |
| miso_oe | output | 1 | Master-in drive enable |
| ss_n_i | input | 1 | Active-low select in (slave) |
| ss_n_o | output | 1 | Active-low select out (master) |
| ss_n_oe | output | 1 | Select drive enable |

## Verification
The bench drives the received line only in the half-period where a correct sampler looks, and inverts it in the other half. A port that samples on the wrong edge for its CPHA setting therefore returns a corrupted byte. A data write placed mid-transfer checks that the bits on `mosi_o` are unaffected and the collision flag is set; a design that accepted the write would corrupt the outgoing stream. A slave abort after three bits followed by a fresh load catches a bit counter that is not reset: the load would be treated as a collision and `miso_o` would carry stale data. With interrupts disabled, the bench confirms that the acknowledge cannot clear the flag.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned RATE_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              en;
    logic              lsb_first;
    logic              cpol;
    logic              cpha;
    logic              master;
    logic              irq_en;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int unsigned DIV_MIN_LOG2 = 2,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned CNT_W = DIV_MIN_LOG2 + (1 << RATE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  // half period = 2^(DIV_MIN_LOG2-1+rate) system clocks
  always_comb begin
    half_m1 = (CNT_W'(1) << (DIV_MIN_LOG2 - 1 + int'(rate))) - CNT_W'(1);
    tick    = run && (cnt == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              abort,
  input  logic              edge_ev,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              in_bit,
  output logic              out_bit,
  output logic              mid_byte,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(EDGES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nxt;
  logic [DATA_W-1:0] sh;
  logic              rx_bit;
  logic              odd_edge, last_edge, sample_edge, shift_held, shift_live;

  // shift register always leaves via its top bit; order is fixed at load/unload
  function automatic logic [DATA_W-1:0] orient(input logic [DATA_W-1:0] v, input logic rev);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = rev ? v[DATA_W-1-i] : v[i];
    return r;
  endfunction

  always_comb begin
    nxt         = cnt + CNT_W'(1);
    odd_edge    = nxt[0];
    last_edge   = (nxt == CNT_W'(EDGES));
    sample_edge = odd_edge ^ cpha;
    shift_held  = cpha ? (odd_edge && (nxt != CNT_W'(1))) : !odd_edge;
    shift_live  = cpha && last_edge;
    out_bit     = sh[DATA_W-1];
    mid_byte    = (cnt != '0);
    rx_word     = orient(sh, lsb_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      rx_bit <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh  <= orient(load_data, lsb_first);
        cnt <= '0;
      end else if (abort) begin
        cnt <= '0;
      end else if (edge_ev) begin
        if (sample_edge) rx_bit <= in_bit;
        if (shift_live)      sh <= {sh[DATA_W-2:0], in_bit};
        else if (shift_held) sh <= {sh[DATA_W-2:0], rx_bit};
        if (last_edge) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/spi_port_top.sv
module spi_port_top
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_MIN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic              ss_n_oe
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              flag_q, wcol_q, ssh_q, auto_q;
  logic              run_q, sck_q;
  logic [DATA_W-1:0] rx_buf;
  logic              sck_s, mosi_s, ss_s, sck_prev, ss_prev;
  logic              is_master, is_slave, data_wr, stat_wr, ctrl_wr;
  logic              busy, start, slave_load, tick, slave_edge;
  logic              edge_ev, abort, in_bit, ss_rise_mid;
  logic              eng_out, mid_byte, eng_done;
  logic [DATA_W-1:0] rx_word;

  spi_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, mosi_i, ss_n_i}), .q({sck_s, mosi_s, ss_s})
  );

  spi_rate_gen #(.DIV_MIN_LOG2(DIV_MIN_LOG2), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run_q), .rate(ctrl_q.rate), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(start || slave_load), .load_data(reg_wdata),
    .abort(abort), .edge_ev(edge_ev), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
    .in_bit(in_bit), .out_bit(eng_out), .mid_byte(mid_byte), .done(eng_done),
    .rx_word(rx_word)
  );

  always_comb begin
    is_master   = ctrl_q.en && ctrl_q.master;
    is_slave    = ctrl_q.en && !ctrl_q.master;
    ctrl_wr     = reg_wr && (reg_addr == REG_CTRL);
    stat_wr     = reg_wr && (reg_addr == REG_STAT);
    data_wr     = reg_wr && (reg_addr == REG_DATA);
    busy        = run_q || (is_slave && mid_byte);
    start       = data_wr && is_master && !run_q;
    slave_load  = data_wr && is_slave && !mid_byte;
    slave_edge  = is_slave && !ss_s && (sck_s != sck_prev);
    edge_ev     = is_master ? tick : slave_edge;
    abort       = !ctrl_q.en || (is_slave && ss_s);
    in_bit      = is_master ? miso_i : mosi_s;
    ss_rise_mid = is_slave && ss_s && !ss_prev && mid_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      ss_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      ss_prev  <= ss_s;
    end
  end

  // master sequencing: run from the accepted write until the byte completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      if (!is_master)    run_q <= 1'b0;
      else if (start)    run_q <= 1'b1;
      else if (eng_done) run_q <= 1'b0;
      if (!run_q || !is_master) sck_q <= ctrl_q.cpol;
      else if (tick)            sck_q <= ~sck_q;
    end
  end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      wcol_q <= 1'b0;
      ssh_q  <= 1'b0;
      auto_q <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (stat_wr) auto_q <= reg_wdata[3];

      if (eng_done)                         flag_q <= 1'b1;
      else if (irq_ack && ctrl_q.irq_en)    flag_q <= 1'b0;
      else if (stat_wr && !reg_wdata[0])    flag_q <= 1'b0;

      if (data_wr && busy)                  wcol_q <= 1'b1;
      else if (stat_wr && !reg_wdata[1])    wcol_q <= 1'b0;

      if (ss_rise_mid)                      ssh_q <= 1'b1;
      else if (stat_wr && !reg_wdata[2])    ssh_q <= 1'b0;

      if (eng_done) rx_buf <= rx_word;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_CTRL: reg_rdata = DATA_W'(ctrl_q);
      REG_STAT: reg_rdata = DATA_W'({auto_q, ssh_q, wcol_q, flag_q});
      REG_DATA: reg_rdata = rx_buf;
      default:  reg_rdata = '0;
    endcase
    irq     = flag_q && ctrl_q.irq_en;
    sck_o   = sck_q;
    sck_oe  = is_master;
    mosi_o  = eng_out;
    mosi_oe = is_master;
    miso_o  = eng_out;
    miso_oe = is_slave && !ss_s;
    ss_n_o  = !(run_q && auto_q && is_master);
    ss_n_oe = is_master && auto_q;
  end
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       irq,
  input logic       irq_ack,
  input logic       sck_oe,
  input logic       miso_oe,
  input logic       ss_n_o,
  input logic       ss_n_oe,
  input logic       flag,
  input logic       wcol,
  input logic       ssh,
  input logic       busy,
  input logic       eng_done,
  input logic       is_master
);
  assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_oe, miso_oe}));

  assert_busy_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && busy) |=> wcol);

  assert_wcol_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(reg_wr && reg_addr == 2'd2));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !eng_done) |=> !irq);

  assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> flag);

  assert_ssh_slave_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssh) |-> $past(!is_master));

  assert_select_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_o |-> (sck_oe && ss_n_oe));
endmodule

bind spi_port_top spi_port_checker chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq(irq), .irq_ack(irq_ack), .sck_oe(sck_oe), .miso_oe(miso_oe),
  .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe), .flag(flag_q), .wcol(wcol_q),
  .ssh(ssh_q), .busy(busy), .eng_done(eng_done), .is_master(is_master)
);

// File: tb/spi_port_top_tb_top.sv
module spi_port_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o, ss_n_oe;

  int checks = 0;
  int fails  = 0;
  logic irq_en_g = 1'b1;
  localparam int SH = 8;

  always #10 clk = ~clk;

  spi_port_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // index of the bit on the wire t clocks after the start edge
  function automatic int bit_idx(input int t, input int h, input logic cpha);
    int q, k;
    q = t / h;
    k = cpha ? ((q == 0) ? 0 : (q - 1) / 2) : q / 2;
    if (k > 7) k = 7;
    return k;
  endfunction

  function automatic int pos_of(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  // master transfer with a cycle-by-cycle reference model of the wire
  task automatic master_xfer(input logic [1:0] rate, input logic cpol, input logic cpha,
                             input logic lsb, input logic [7:0] tx, input logic [7:0] srx,
                             input int collide_t);
    int h, q, k;
    logic [7:0] rd;
    logic good;
    h = 2 << rate;
    reg_write(2'd0, {1'b1, lsb, cpol, cpha, 1'b1, irq_en_g, rate});
    reg_write(2'd1, 8'h08);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = tx;
    for (int t = 0; t <= 16 * h + 1; t++) begin
      @(negedge clk);
      if (t == 0) reg_wr = 1'b0;
      if (t == collide_t) begin
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = ~tx;
      end else if (t == collide_t + 1) begin
        reg_wr = 1'b0;
      end
      q = t / h;
      k = bit_idx(t, h, cpha);
      chk("R2 sck_o", sck_o, cpol ^ q[0]);
      if (t < 16 * h) chk("R3/R4 mosi_o", mosi_o, tx[pos_of(k, lsb)]);
      chk("R11 ss_n_o", ss_n_o, (t <= 16 * h) ? 1'b0 : 1'b1);
      chk("R11 ss_n_oe", ss_n_oe, 1'b1);
      chk("R6/R7 irq", irq, (t >= 16 * h + 1) ? irq_en_g : 1'b0);
      // valid only in the half-period the correct sampler looks at
      good = (q[0] == cpha);
      miso_i = srx[pos_of(k, lsb)] ^ !good;
    end
    reg_read(2'd2, rd);
    chk("R5 rx byte", rd, srx);
    reg_read(2'd1, rd);
    chk("R6 done flag", rd[0], 1'b1);
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic lsb,
                            input logic [7:0] dut_tx, input logic [7:0] bench_tx,
                            input int nbits, output logic [7:0] got);
    int p;
    reg_write(2'd0, {1'b1, lsb, cpol, cpha, 1'b0, 1'b0, 2'b00});
    @(negedge clk); sck_i = cpol; ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    reg_write(2'd1, 8'h00);
    reg_write(2'd2, dut_tx);
    ss_n_i = 1'b0;
    repeat (SH) @(negedge clk);
    got = 8'h00;
    for (int k = 0; k < nbits; k++) begin
      p = pos_of(k, lsb);
      if (!cpha) begin
        mosi_i = bench_tx[p];
        repeat (SH) @(negedge clk);
        sck_i = ~sck_i; got[p] = miso_o;
        repeat (SH) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i; mosi_i = bench_tx[p];
        repeat (SH) @(negedge clk);
        sck_i = ~sck_i; got[p] = miso_o;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (SH) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd, got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe, ss_n_oe}, 4'b0000);
    chk("R1 ss_n_o", ss_n_o, 1'b1);
    reg_read(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
    reg_read(2'd1, rd); chk("R1 status", rd, 8'h00);
    reg_read(2'd2, rd); chk("R1 data", rd, 8'h00);

    // master modes, interrupts enabled
    irq_en_g = 1'b1;
    master_xfer(2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, -10);
    chk("R7 irq before ack", irq, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 irq after ack", irq, 1'b0);
    reg_read(2'd1, rd); chk("R7 flag cleared by ack", rd[0], 1'b0);

    master_xfer(2'd1, 1'b1, 1'b1, 1'b1, 8'h96, 8'hE1, 5);
    reg_read(2'd1, rd); chk("R8 collision flag", rd[1], 1'b1);

    master_xfer(2'd3, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80, -10);
    reg_read(2'd1, rd); chk("R8 no collision", rd[1], 1'b0);

    // interrupts disabled
    irq_en_g = 1'b0;
    master_xfer(2'd2, 1'b1, 1'b0, 1'b1, 8'h4B, 8'hD2, -10);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 irq masked", irq, 1'b0);
    reg_read(2'd1, rd); chk("R7 ack ignored when disabled", rd[0], 1'b1);
    reg_write(2'd1, 8'h08);
    reg_read(2'd1, rd); chk("R7 software clear", rd[0], 1'b0);

    // R12 disabled port
    reg_write(2'd0, 8'h0C);
    reg_write(2'd2, 8'h77);
    repeat (200) @(negedge clk);
    chk("R12 no select", ss_n_o, 1'b1);
    reg_read(2'd1, rd); chk("R12 no done", rd[0], 1'b0);
    reg_read(2'd2, rd); chk("R12 data kept", rd, 8'hD2);

    // slave mode
    slave_xfer(1'b0, 1'b0, 1'b0, 8'h5A, 8'hC7, 8, got);
    chk("R9 miso byte", got, 8'h5A);
    reg_read(2'd2, rd); chk("R9 rx byte", rd, 8'hC7);
    reg_read(2'd1, rd); chk("R6 slave done", rd[0], 1'b1);

    slave_xfer(1'b1, 1'b1, 1'b1, 8'h3E, 8'h81, 8, got);
    chk("R9/R4 miso byte lsb", got, 8'h3E);
    reg_read(2'd2, rd); chk("R9/R4 rx byte lsb", rd, 8'h81);

    slave_xfer(1'b0, 1'b1, 1'b0, 8'hF0, 8'h0F, 3, got);
    reg_read(2'd1, rd);
    chk("R10 select-rose flag", rd[2], 1'b1);
    chk("R10 no done on abort", rd[0], 1'b0);
    reg_read(2'd2, rd); chk("R10 data kept on abort", rd, 8'h81);

    slave_xfer(1'b0, 1'b1, 1'b0, 8'h99, 8'h42, 8, got);
    chk("R10 miso after abort", got, 8'h99);
    reg_read(2'd2, rd); chk("R10 rx after abort", rd, 8'h42);
    reg_read(2'd1, rd); chk("R10 no collision after abort", rd[1], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule